// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Time Insertion

This block drives one PWM channel as a pair of outputs: a primary output and, when pairing is on, its complement. A free-running timer, clocked through a power-of-two prescaler, counts from zero up to a programmable terminal value and then wraps. Two independent 16-bit compare values mark the count at which the primary level turns on and the count at which it turns off. Together they set the period and the duty cycle without any duty arithmetic.

Before either output turns on, a non-overlap gap is inserted. This gap is counted in undivided system clocks, not in timer ticks, so it keeps its resolution at any prescale setting. Turn-off edges take effect one clock after the internal level changes. Because only turn-on edges are delayed, the two outputs are never high together. The configuration is static: it is written while the block is held in reset or disabled. The dead time must be shorter than both the high and low spacing of the compare edges. A configuration that breaks this rule is an error, and the block does not define its output in that case. There is no streaming data path, so every pin is a plain level.

Top module: `cpwm_dt_top`

## Requirements
- R1: While `rst` is high (synchronous, active high), both `pwm_p` and `pwm_n` are low from the first clock edge on.
- R2: The timer advances once every 2^`presc_sel` system clocks. The encodings are 0 for divide-by-1, 1 for divide-by-2, 2 for divide-by-4 and 3 for divide-by-8.
- R3: The timer counts 0, 1, ..., `reload` and then wraps to 0, so the output period is (`reload`+1) × divisor system clocks.
- R4: When pairing is active, an output's rising edge follows the other output's falling edge by exactly `dly` system clocks, for `dly` from 0 to 15.
- R5: `pwm_p` and `pwm_n` are never high in the same cycle.
- R6: The internal level turns on at the tick where the count equals `rise_cmp` and turns off at the tick where it equals `fall_cmp`. The primary output is therefore high for (`fall_cmp`−`rise_cmp`)×divisor−`dly` clocks, and the complement is high for the remainder of the period minus `dly`.
- R7: Both outputs are held low one clock after any of `pwm_en`, `ch_en` or `multi_en` is low.
- R8: With `pair_en` low, `pwm_n` stays low and `pwm_p` keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_en | input | 1 | Global PWM enable; also lets the timer run |
| ch_en | input | 1 | Channel enable |
| multi_en | input | 1 | Multi-edge compare mode enable |
| pair_en | input | 1 | Enables the complementary output |
| presc_sel | input | 2 | Prescaler select, divisor 2^value |
| reload | input | 16 | Terminal count of the timer |
| rise_cmp | input | 16 | Count at which the primary level turns on |
| fall_cmp | input | 16 | Count at which the primary level turns off |
| dly | input | 4 | Non-overlap delay in system clocks |
| pwm_p | output | 1 | Primary output |
| pwm_n | output | 1 | Complementary output |

## Verification
The assertions check the following on every cycle: the outputs never overlap, the outputs are silenced after a disable or with pairing off, the timer holds between ticks, and each turn-on waits at least `dly` clocks after the partner goes low. The exact gap, the widths of both pulses and the period depend on the divisor, the compares and the delay together. Only the bench's scenarios can show them, by timing the output edges over whole periods at several prescale and delay settings, including zero and maximum delay.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int CNT_W = 16;
  localparam int DLY_W = 4;
  localparam int PS_W  = 2;
  localparam int N_OUT = 2;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [DLY_W-1:0] dly_t;
  typedef logic [PS_W-1:0]  psel_t;

  typedef enum logic [0:0] {
    OUT_PRI  = 1'b0,
    OUT_COMP = 1'b1
  } out_idx_e;
endpackage

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  localparam int PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0] pcnt_q;
  logic [PC_W-1:0] lim;

  always_comb begin
    lim = '0;
    for (int i = 0; i < PC_W; i++) begin
      if (i < int'(sel)) lim[i] = 1'b1;
    end
  end

  assign tick = run && (pcnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt_q <= '0;
    end else if (pcnt_q == lim) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cpwm_period_cnt.sv
module cpwm_period_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt >= reload) cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cpwm_edge_gen.sv
module cpwm_edge_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] rise_cmp,
  input  logic [CNT_W-1:0] fall_cmp,
  output logic             level
);
  logic hit_rise;
  logic hit_fall;

  assign hit_rise = tick && (cnt == rise_cmp);
  assign hit_fall = tick && (cnt == fall_cmp);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      level <= 1'b0;
    end else if (hit_rise) begin
      level <= 1'b1;
    end else if (hit_fall) begin
      level <= 1'b0;
    end
  end
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             want,
  input  logic [DLY_W-1:0] dly,
  output logic             out
);
  logic [DLY_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out    <= 1'b0;
      wait_q <= dly;
    end else if (!want) begin
      out    <= 1'b0;
      wait_q <= dly;
    end else if (!out) begin
      if (wait_q == '0) out <= 1'b1;
      else              wait_q <= wait_q - 1'b1;
    end
  end
endmodule

// File: rtl/cpwm_dt_top.sv
module cpwm_dt_top
  import cpwm_pkg::*;
#(
  parameter int P_CNT_W = CNT_W,
  parameter int P_DLY_W = DLY_W,
  parameter int P_PS_W  = PS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwm_en,
  input  logic               ch_en,
  input  logic               multi_en,
  input  logic               pair_en,
  input  logic [P_PS_W-1:0]  presc_sel,
  input  logic [P_CNT_W-1:0] reload,
  input  logic [P_CNT_W-1:0] rise_cmp,
  input  logic [P_CNT_W-1:0] fall_cmp,
  input  logic [P_DLY_W-1:0] dly,
  output logic               pwm_p,
  output logic               pwm_n
);
  logic               tick_w;
  logic [P_CNT_W-1:0] cnt_q;
  logic               level_q;
  logic               chan_on;
  logic [N_OUT-1:0]   want;
  logic [N_OUT-1:0]   outs;

  cpwm_prescaler #(.PS_W(P_PS_W)) u_presc (
    .clk (clk), .rst (rst), .run (pwm_en), .sel (presc_sel), .tick (tick_w)
  );

  cpwm_period_cnt #(.CNT_W(P_CNT_W)) u_cnt (
    .clk (clk), .rst (rst), .run (pwm_en), .tick (tick_w),
    .reload (reload), .cnt (cnt_q)
  );

  cpwm_edge_gen #(.CNT_W(P_CNT_W)) u_edge (
    .clk (clk), .rst (rst), .run (pwm_en), .tick (tick_w), .cnt (cnt_q),
    .rise_cmp (rise_cmp), .fall_cmp (fall_cmp), .level (level_q)
  );

  assign chan_on         = pwm_en && ch_en && multi_en;
  assign want[OUT_PRI]   = chan_on && level_q;
  assign want[OUT_COMP]  = chan_on && pair_en && !level_q;

  for (genvar g = 0; g < N_OUT; g++) begin : g_dt
    cpwm_deadtime #(.DLY_W(P_DLY_W)) u_dt (
      .clk (clk), .rst (rst), .want (want[g]), .dly (dly), .out (outs[g])
    );
  end

  assign pwm_p = outs[OUT_PRI];
  assign pwm_n = outs[OUT_COMP];
endmodule

// File: rtl/cpwm_dt_checker.sv
module cpwm_dt_checker #(
  parameter int CNT_W = 16,
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pwm_en,
  input logic             ch_en,
  input logic             multi_en,
  input logic             pair_en,
  input logic [DLY_W-1:0] dly,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             pwm_p,
  input logic             pwm_n
);
  localparam int LC_W = DLY_W + 1;

  logic [LC_W-1:0] p_low_q;
  logic [LC_W-1:0] n_low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_low_q <= '0;
      n_low_q <= '0;
    end else begin
      if (pwm_p)           p_low_q <= '0;
      else if (~&p_low_q)  p_low_q <= p_low_q + 1'b1;
      if (pwm_n)           n_low_q <= '0;
      else if (~&n_low_q)  n_low_q <= n_low_q + 1'b1;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(pwm_p && pwm_n)); // R5

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !(pwm_en && ch_en && multi_en) |=> (!pwm_p && !pwm_n)); // R7

  AST_COMP_OFF_UNPAIRED: assert property (@(posedge clk) disable iff (rst)
    !pair_en |=> !pwm_n); // R8

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && pwm_en) |=> (cnt == $past(cnt))); // R2

  AST_GAP_BEFORE_P: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwm_p) && $stable(dly)) |-> (n_low_q >= LC_W'(dly))); // R4

  AST_GAP_BEFORE_N: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwm_n) && $stable(dly)) |-> (p_low_q >= LC_W'(dly))); // R4
endmodule

bind cpwm_dt_top cpwm_dt_checker #(.CNT_W(P_CNT_W), .DLY_W(P_DLY_W)) u_chk (
  .clk (clk), .rst (rst), .pwm_en (pwm_en), .ch_en (ch_en),
  .multi_en (multi_en), .pair_en (pair_en), .dly (dly), .tick (tick_w),
  .cnt (cnt_q), .pwm_p (pwm_p), .pwm_n (pwm_n)
);

// File: tb/cpwm_dt_top_tb.sv
module cpwm_dt_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwm_en = 1'b0, ch_en = 1'b0, multi_en = 1'b0, pair_en = 1'b0;
  logic [1:0]  presc_sel = '0;
  logic [15:0] reload = '0, rise_cmp = '0, fall_cmp = '0;
  logic [3:0]  dly = '0;
  logic        pwm_p, pwm_n;

  int n_checks = 0;
  int n_err = 0;
  int overlap_cnt = 0;
  bit done = 1'b0;

  cpwm_dt_top u_dut (
    .clk (clk), .rst (rst), .pwm_en (pwm_en), .ch_en (ch_en),
    .multi_en (multi_en), .pair_en (pair_en), .presc_sel (presc_sel),
    .reload (reload), .rise_cmp (rise_cmp), .fall_cmp (fall_cmp),
    .dly (dly), .pwm_p (pwm_p), .pwm_n (pwm_n)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (!rst && pwm_p && pwm_n) overlap_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input int rl, input int rs,
                     input int fl, input int d, input bit pr,
                     input bit e0, input bit e1, input bit e2);
    @(negedge clk);
    rst = 1'b1;
    presc_sel = sel; reload = 16'(rl); rise_cmp = 16'(rs); fall_cmp = 16'(fl);
    dly = 4'(d); pair_en = pr; pwm_en = e0; ch_en = e1; multi_en = e2;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Times p rise, p fall, n rise, n fall, p rise in that order.
  task automatic measure(input string tag, input int pw, input int gap,
                         input int nw, input int per);
    int t[5];
    int stage = 0;
    int cyc = 0;
    logic pp, pn;
    pp = pwm_p; pn = pwm_n;
    while (stage < 5 && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (stage == 0 && pwm_p && !pp)  begin t[0] = cyc; stage = 1; end
      if (stage == 1 && !pwm_p && pp)  begin t[1] = cyc; stage = 2; end
      if (stage == 2 && pwm_n && !pn)  begin t[2] = cyc; stage = 3; end
      if (stage == 3 && !pwm_n && pn)  begin t[3] = cyc; stage = 4; end
      if (stage == 4 && pwm_p && !pp)  begin t[4] = cyc; stage = 5; end
      pp = pwm_p; pn = pwm_n;
    end
    chk({tag, " R6 edges seen"}, stage, 5);
    if (stage == 5) begin
      chk({tag, " R6 primary width"}, t[1] - t[0], pw);
      chk({tag, " R4 gap p-off to n-on"}, t[2] - t[1], gap);
      chk({tag, " R6 complement width"}, t[3] - t[2], nw);
      chk({tag, " R4 gap n-off to p-on"}, t[4] - t[3], gap);
      chk({tag, " R3 period"}, t[4] - t[0], per);
    end
  endtask

  task automatic count_high(input int cycles, output int hp, output int hn);
    hp = 0; hn = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_p) hp++;
      if (pwm_n) hn++;
    end
  endtask

  task automatic t_reset();
    cfg(2'd0, 12, 4, 8, 0, 1'b1, 1'b1, 1'b1, 1'b1);
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset p", int'(pwm_p), 0);
    chk("R1 reset n", int'(pwm_n), 0);
    @(negedge clk);
    chk("R1 reset held n", int'(pwm_n), 0);
  endtask

  task automatic t_main();
    cfg(2'd2, 12, 4, 8, 3, 1'b1, 1'b1, 1'b1, 1'b1);
    measure("div4 dly3", 13, 3, 33, 52);
  endtask

  task automatic t_nodelay();
    cfg(2'd2, 12, 4, 8, 0, 1'b1, 1'b1, 1'b1, 1'b1);
    measure("div4 dly0", 16, 0, 36, 52);
  endtask

  task automatic t_maxdelay();
    cfg(2'd0, 40, 10, 30, 15, 1'b1, 1'b1, 1'b1, 1'b1);
    measure("div1 dly15", 5, 15, 6, 41);
  endtask

  task automatic t_div2();
    cfg(2'd1, 12, 4, 8, 3, 1'b1, 1'b1, 1'b1, 1'b1);
    measure("R2 div2", 5, 3, 15, 26);
  endtask

  task automatic t_div8();
    cfg(2'd3, 12, 4, 8, 3, 1'b1, 1'b1, 1'b1, 1'b1);
    measure("R2 div8", 29, 3, 69, 104);
  endtask

  task automatic t_nopair();
    int hp, hn;
    cfg(2'd2, 12, 4, 8, 3, 1'b0, 1'b1, 1'b1, 1'b1);
    count_high(208, hp, hn);
    chk("R8 complement stays low", hn, 0);
    chk("R8 primary still runs (high cycles)", hp, 4 * 13);
  endtask

  task automatic t_disable();
    int hp, hn;
    cfg(2'd0, 12, 4, 8, 2, 1'b1, 1'b0, 1'b1, 1'b1);
    count_high(100, hp, hn);
    chk("R7 pwm_en off p", hp, 0);
    chk("R7 pwm_en off n", hn, 0);
    cfg(2'd0, 12, 4, 8, 2, 1'b1, 1'b1, 1'b0, 1'b1);
    count_high(100, hp, hn);
    chk("R7 ch_en off p+n", hp + hn, 0);
    cfg(2'd0, 12, 4, 8, 2, 1'b1, 1'b1, 1'b1, 1'b0);
    count_high(100, hp, hn);
    chk("R7 multi_en off p+n", hp + hn, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_main();
    t_nodelay();
    t_maxdelay();
    t_div2();
    t_div8();
    t_nopair();
    t_disable();
    chk("R5 overlap cycles", overlap_cnt, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule